// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the tag-lookup stage of a four-way set-associative data cache. A request carries a virtual address. The set index is taken only from the page-offset part of that address, so the tag array can be read in the same cycle that a small fully associative translation buffer turns the virtual page number into a physical page number. The physical page number is then compared with the physical tags of every way in the selected set. The result is registered and appears one cycle after the request: hit with the hit way, miss, or translation miss.

Because the index never uses translated bits and the tags are physical, two virtual pages that map to the same physical page find the same set and match the same stored tag. Aliased mappings therefore share one line and cannot leave two copies in the cache. Translation entries are loaded through a direct write port. Lines are installed through a refill port that takes a set number and a physical tag. The refill port picks the way itself: it reuses a way that already holds the same tag, and otherwise takes the lowest free way or the way named by a per-set round-robin pointer.

Top module: `vipt_lookup`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every cache valid bit, every translation valid bit and every round-robin pointer. While reset is held and in the cycle after it, all response outputs are low. After reset every lookup reports a translation miss. Once a translation is loaded again, a lookup reports a cache miss until a line is installed.
- R2: A request accepted at edge N produces `rsp_valid` high for exactly the cycle after edge N. When `rsp_valid` is low, `rsp_hit`, `rsp_miss`, `rsp_tlb_miss` and `rsp_way` are all low.
- R3: The virtual page number is `req_vaddr[31:12]` and the set index is `req_vaddr[11:6]`, giving 64 sets of 64-byte lines. `req_vaddr[5:0]` has no effect on the result.
- R4: The translation buffer has 8 entries. A write to entry `tlb_wr_idx` stores the virtual page number and physical page number and marks the entry valid, replacing whatever it held. If several valid entries hold the requested page number, the lowest-numbered entry supplies the translation.
- R5: If no valid translation entry matches, the response has `rsp_tlb_miss` high and both `rsp_hit` and `rsp_miss` low. Every response raises exactly one of the three flags.
- R6: If the translation succeeds and a valid way of the indexed set holds a tag equal to the 24-bit physical page number (physical address bits [35:12]), the response has `rsp_hit` high and `rsp_way` equal to that way's number (0 to 3). `rsp_way` is 0 whenever `rsp_hit` is low.
- R7: If the translation succeeds and no valid way of the indexed set holds the physical page number, the response has `rsp_miss` high.
- R8: Two virtual addresses with different page numbers that translate to the same physical page and share bits [11:6] hit the same way.
- R9: A refill into a set that holds fewer than four valid lines, none of them with the refill tag, writes the lowest-numbered invalid way.
- R10: Each set has a 2-bit pointer that is 0 after reset and advances by one (mod 4) on every refill that allocates a way. When all four ways are valid, an allocating refill replaces the way the pointer names.
- R11: A refill whose tag is already valid in the set rewrites that way. It allocates nothing and leaves the pointer unchanged, so no set ever holds two valid copies of one tag.
- R12: A lookup presented in the same cycle as a refill to the same set sees the set as it was before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request valid |
| req_vaddr | input | 32 | Virtual address of the lookup |
| tlb_wr_en | input | 1 | Write one translation entry |
| tlb_wr_idx | input | 3 | Entry number to write |
| tlb_wr_vpn | input | 20 | Virtual page number to store |
| tlb_wr_ppn | input | 24 | Physical page number to store |
| fill_valid | input | 1 | Install a line |
| fill_set | input | 6 | Set that receives the line |
| fill_ptag | input | 24 | Physical tag of the installed line |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Line present |
| rsp_miss | output | 1 | Translation succeeded, line absent |
| rsp_tlb_miss | output | 1 | No translation entry matched |
| rsp_way | output | 2 | Hit way, 0 when not a hit |

## Verification
The bench builds the block with its default parameters: 32-bit virtual and 36-bit physical addresses, 4 KB pages, 64-byte lines, four ways and eight translation entries. With so few translation entries and only four ways, a random stream confined to four sets and small pools of page numbers keeps reaching the hard cases. These are full sets, where the round-robin pointer decides the victim, and duplicate refills. They also include aliases that map to one physical page and repeated page numbers in the translation buffer, where the lowest-entry priority decides. Directed sequences pin down the exact victim order, the same-cycle lookup-and-refill case and a reset in the middle of a run.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

   // Outcome of one lookup, registered in the response stage.
   typedef enum logic [1:0] {
      LK_NONE     = 2'd0,
      LK_HIT      = 2'd1,
      LK_MISS     = 2'd2,
      LK_TLB_MISS = 2'd3
   } lookup_kind_e;

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 24,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn
);

   logic [ENTRIES-1:0] ent_vld_q;
   logic [VPN_W-1:0]   ent_vpn_q [ENTRIES];
   logic [PPN_W-1:0]   ent_ppn_q [ENTRIES];
   logic [ENTRIES-1:0] ent_match;

   always_ff @(posedge clk) begin
      if (rst) begin
         ent_vld_q <= '0;
      end else if (wr_en) begin
         ent_vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         ent_vpn_q[wr_idx] <= wr_vpn;
         ent_ppn_q[wr_idx] <= wr_ppn;
      end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cam
      assign ent_match[e] = ent_vld_q[e] && (ent_vpn_q[e] == lk_vpn);
   end

   // Lowest-numbered matching entry wins: scan downward, last write sticks.
   always_comb begin
      lk_hit = 1'b0;
      lk_ppn = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (ent_match[e]) begin
            lk_hit = 1'b1;
            lk_ppn = ent_ppn_q[e];
         end
      end
   end

   AST_TLB_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> (ent_vld_q != '0)) else $error("hit with empty buffer"); // R4

endmodule

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
   parameter int SETS   = 64,
   parameter int WAYS   = 4,
   parameter int TAG_W  = 24,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rst,
   // lookup read port
   input  logic [SET_W-1:0]            a_set,
   output logic [WAYS-1:0]             a_vld,
   output logic [WAYS-1:0][TAG_W-1:0]  a_tag,
   // refill read port
   input  logic [SET_W-1:0]            b_set,
   output logic [WAYS-1:0]             b_vld,
   output logic [WAYS-1:0][TAG_W-1:0]  b_tag,
   // write port
   input  logic                        wr_en,
   input  logic [SET_W-1:0]            wr_set,
   input  logic [WAY_W-1:0]            wr_way,
   input  logic [TAG_W-1:0]            wr_tag
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]  vld_q;
      logic [TAG_W-1:0] tag_q [SETS];
      logic             sel;

      assign sel = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= '0;
         end else if (sel) begin
            vld_q[wr_set] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[wr_set] <= wr_tag;
         end
      end

      assign a_vld[w] = vld_q[a_set];
      assign a_tag[w] = tag_q[a_set];
      assign b_vld[w] = vld_q[b_set];
      assign b_tag[w] = tag_q[b_set];
   end

endmodule

// File: rtl/vipt_fill_ctrl.sv
module vipt_fill_ctrl #(
   parameter int SETS   = 64,
   parameter int WAYS   = 4,
   parameter int TAG_W  = 24,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        fill_valid,
   input  logic [SET_W-1:0]            fill_set,
   input  logic [TAG_W-1:0]            fill_tag,
   input  logic [WAYS-1:0]             set_vld,
   input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
   output logic                        wr_en,
   output logic [WAY_W-1:0]            wr_way
);

   logic [WAY_W-1:0] rr_q [SETS];
   logic [WAYS-1:0]  dup_vec;
   logic [WAYS-1:0]  free_vec;
   logic [WAY_W-1:0] dup_way;
   logic [WAY_W-1:0] free_way;
   logic             any_dup;
   logic             any_free;
   logic             alloc;

   for (genvar w = 0; w < WAYS; w++) begin : g_scan
      assign dup_vec[w]  = set_vld[w] && (set_tag[w] == fill_tag);
      assign free_vec[w] = !set_vld[w];
   end

   assign any_dup  = |dup_vec;
   assign any_free = |free_vec;

   always_comb begin
      dup_way  = '0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (dup_vec[w])  dup_way  = WAY_W'(w);
         if (free_vec[w]) free_way = WAY_W'(w);
      end
   end

   always_comb begin
      if (any_dup)       wr_way = dup_way;
      else if (any_free) wr_way = free_way;
      else               wr_way = rr_q[fill_set];
   end

   assign wr_en = fill_valid;
   assign alloc = fill_valid && !any_dup;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      end else if (alloc) begin
         rr_q[fill_set] <= rr_q[fill_set] + WAY_W'(1);
      end
   end

   AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (rst)
      (fill_valid && !any_dup && any_free) |-> !set_vld[wr_way]) else $error("valid way evicted while free way exists"); // R9
   AST_DUP_REUSED: assert property (@(posedge clk) disable iff (rst)
      (fill_valid && any_dup) |-> (set_tag[wr_way] == fill_tag)) else $error("duplicate tag not reused"); // R11

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
   import vipt_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 36,
   parameter int PAGE_BITS = 12,
   parameter int LINE_BITS = 6,
   parameter int WAYS      = 4,
   parameter int TLB_ENT   = 8,
   localparam int SET_W    = PAGE_BITS - LINE_BITS,
   localparam int SETS     = 1 << SET_W,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int TAG_W    = PA_W - PAGE_BITS,
   localparam int WAY_W    = $clog2(WAYS),
   localparam int TIDX_W   = (TLB_ENT > 1) ? $clog2(TLB_ENT) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic              tlb_wr_en,
   input  logic [TIDX_W-1:0] tlb_wr_idx,
   input  logic [VPN_W-1:0]  tlb_wr_vpn,
   input  logic [TAG_W-1:0]  tlb_wr_ppn,
   input  logic              fill_valid,
   input  logic [SET_W-1:0]  fill_set,
   input  logic [TAG_W-1:0]  fill_ptag,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_tlb_miss,
   output logic [WAY_W-1:0]  rsp_way
);

   // Elaboration-time parameter checks.
   if (PAGE_BITS <= LINE_BITS) begin : g_bad_page
      $error("page offset must be wider than the line offset");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("way count must be a power of two of at least 2");
   end
   if (VA_W <= PAGE_BITS || PA_W <= PAGE_BITS) begin : g_bad_addr
      $error("addresses must be wider than the page offset");
   end
   if (TLB_ENT < 1) begin : g_bad_tlb
      $error("translation buffer needs at least one entry");
   end

   logic [VPN_W-1:0]           lk_vpn;
   logic [SET_W-1:0]           lk_set;
   logic                       tlb_hit;
   logic [TAG_W-1:0]           tlb_ppn;
   logic [WAYS-1:0]            a_vld;
   logic [WAYS-1:0][TAG_W-1:0] a_tag;
   logic [WAYS-1:0]            b_vld;
   logic [WAYS-1:0][TAG_W-1:0] b_tag;
   logic                       arr_wr_en;
   logic [WAY_W-1:0]           arr_wr_way;
   logic [WAYS-1:0]            way_match;
   logic [WAY_W-1:0]           match_way;
   lookup_kind_e               kind_d, kind_q;
   logic [WAY_W-1:0]           way_d, way_q;

   // Index and page number both come straight from the virtual address.
   assign lk_vpn = req_vaddr[VA_W-1:PAGE_BITS];
   assign lk_set = req_vaddr[PAGE_BITS-1:LINE_BITS];

   vipt_tlb #(
      .ENTRIES (TLB_ENT),
      .VPN_W   (VPN_W),
      .PPN_W   (TAG_W)
   ) tlb_i (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (tlb_wr_en),
      .wr_idx (tlb_wr_idx),
      .wr_vpn (tlb_wr_vpn),
      .wr_ppn (tlb_wr_ppn),
      .lk_vpn (lk_vpn),
      .lk_hit (tlb_hit),
      .lk_ppn (tlb_ppn)
   );

   vipt_tag_array #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .TAG_W (TAG_W)
   ) tags_i (
      .clk    (clk),
      .rst    (rst),
      .a_set  (lk_set),
      .a_vld  (a_vld),
      .a_tag  (a_tag),
      .b_set  (fill_set),
      .b_vld  (b_vld),
      .b_tag  (b_tag),
      .wr_en  (arr_wr_en),
      .wr_set (fill_set),
      .wr_way (arr_wr_way),
      .wr_tag (fill_ptag)
   );

   vipt_fill_ctrl #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .TAG_W (TAG_W)
   ) fill_i (
      .clk        (clk),
      .rst        (rst),
      .fill_valid (fill_valid),
      .fill_set   (fill_set),
      .fill_tag   (fill_ptag),
      .set_vld    (b_vld),
      .set_tag    (b_tag),
      .wr_en      (arr_wr_en),
      .wr_way     (arr_wr_way)
   );

   // Physical tag compare across all ways.
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign way_match[w] = a_vld[w] && (a_tag[w] == tlb_ppn);
   end

   always_comb begin
      match_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (way_match[w]) match_way = WAY_W'(w);
      end
   end

   always_comb begin
      kind_d = LK_NONE;
      way_d  = '0;
      if (req_valid) begin
         if (!tlb_hit) begin
            kind_d = LK_TLB_MISS;
         end else if (|way_match) begin
            kind_d = LK_HIT;
            way_d  = match_way;
         end else begin
            kind_d = LK_MISS;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q <= LK_NONE;
         way_q  <= '0;
      end else begin
         kind_q <= kind_d;
         way_q  <= way_d;
      end
   end

   assign rsp_valid    = (kind_q != LK_NONE);
   assign rsp_hit      = (kind_q == LK_HIT);
   assign rsp_miss     = (kind_q == LK_MISS);
   assign rsp_tlb_miss = (kind_q == LK_TLB_MISS);
   assign rsp_way      = way_q;

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> !rsp_valid) else $error("response after reset"); // R1
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid) else $error("request without response"); // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !rsp_valid) else $error("response without request"); // R2
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_tlb_miss}) == 1)) else $error("outcome flags not exclusive"); // R5
   AST_WAY_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
      !rsp_hit |-> (rsp_way == '0)) else $error("way reported without hit"); // R6
   AST_NO_DUP_TAGS: assert property (@(posedge clk) disable iff (rst)
      (req_valid && tlb_hit) |-> $onehot0(way_match)) else $error("tag present in two ways"); // R11

endmodule

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb_top;

   localparam int SETS = 64;
   localparam int WAYS = 4;
   localparam int TLBN = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        tlb_wr_en = 1'b0;
   logic [2:0]  tlb_wr_idx = '0;
   logic [19:0] tlb_wr_vpn = '0;
   logic [23:0] tlb_wr_ppn = '0;
   logic        fill_valid = 1'b0;
   logic [5:0]  fill_set = '0;
   logic [23:0] fill_ptag = '0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_tlb_miss;
   logic [1:0]  rsp_way;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Reference model state
   bit          m_tv   [TLBN];
   logic [19:0] m_tvpn [TLBN];
   logic [23:0] m_tppn [TLBN];
   bit          m_cv   [SETS][WAYS];
   logic [23:0] m_ctag [SETS][WAYS];
   int          m_ptr  [SETS];

   always #5 clk = ~clk;

   vipt_lookup dut_i (
      .clk, .rst, .req_valid, .req_vaddr,
      .tlb_wr_en, .tlb_wr_idx, .tlb_wr_vpn, .tlb_wr_ppn,
      .fill_valid, .fill_set, .fill_ptag,
      .rsp_valid, .rsp_hit, .rsp_miss, .rsp_tlb_miss, .rsp_way
   );

   function automatic void m_reset();
      for (int e = 0; e < TLBN; e++) m_tv[e] = 1'b0;
      for (int s = 0; s < SETS; s++) begin
         m_ptr[s] = 0;
         for (int w = 0; w < WAYS; w++) m_cv[s][w] = 1'b0;
      end
   endfunction

   // kind: 0 hit, 1 miss, 2 translation miss
   function automatic void m_lookup(input logic [31:0] va, output int kind, output int way);
      int s = int'(va[11:6]);
      bit th = 1'b0;
      logic [23:0] p = '0;
      for (int e = 0; e < TLBN; e++)
         if (!th && m_tv[e] && m_tvpn[e] == va[31:12]) begin th = 1'b1; p = m_tppn[e]; end
      way = 0;
      if (!th) kind = 2;
      else begin
         kind = 1;
         for (int w = 0; w < WAYS; w++)
            if (kind == 1 && m_cv[s][w] && m_ctag[s][w] == p) begin kind = 0; way = w; end
      end
   endfunction

   function automatic void m_fill(input int s, input logic [23:0] t);
      int v = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (m_cv[s][w] && m_ctag[s][w] == t) v = w;
      if (v < 0) begin
         for (int w = WAYS - 1; w >= 0; w--) if (!m_cv[s][w]) v = w;
         if (v < 0) v = m_ptr[s];
         m_ptr[s] = (m_ptr[s] + 1) % WAYS;
      end
      m_cv[s][v]   = 1'b1;
      m_ctag[s][v] = t;
   endfunction

   task automatic check(input bit ok, input string req, input string act, input string exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   task automatic check_rsp(input string req, input bit vld, input int kind, input int way);
      bit eh = vld && kind == 0, em = vld && kind == 1, et = vld && kind == 2;
      int ew = eh ? way : 0;
      check(rsp_valid === vld && rsp_hit === eh && rsp_miss === em && rsp_tlb_miss === et
            && rsp_way === 2'(ew), req,
            $sformatf("v%0b h%0b m%0b t%0b w%0d", rsp_valid, rsp_hit, rsp_miss, rsp_tlb_miss, rsp_way),
            $sformatf("v%0b h%0b m%0b t%0b w%0d", vld, eh, em, et, ew));
   endtask

   task automatic tlb_write(input int idx, input logic [19:0] vpn, input logic [23:0] ppn);
      @(negedge clk);
      tlb_wr_en = 1'b1; tlb_wr_idx = 3'(idx); tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
      @(negedge clk);
      tlb_wr_en = 1'b0;
      m_tv[idx] = 1'b1; m_tvpn[idx] = vpn; m_tppn[idx] = ppn;
   endtask

   task automatic fill(input int s, input logic [23:0] t);
      @(negedge clk);
      fill_valid = 1'b1; fill_set = 6'(s); fill_ptag = t;
      @(negedge clk);
      fill_valid = 1'b0;
      m_fill(s, t);
   endtask

   task automatic lookup(input logic [31:0] va, input string req);
      int k, w;
      m_lookup(va, k, w);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp(req, 1'b1, k, w);
   endtask

   task automatic lookup_exp(input logic [31:0] va, input int k, input int w, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp(req, 1'b1, k, w);
   endtask

   function automatic logic [31:0] va_of(input logic [19:0] vpn, input int s, input int off);
      return {vpn, 6'(s), 6'(off)};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_rsp("R1 outputs low in reset", 1'b0, 0, 0);
      rst = 1'b0;
      @(negedge clk);
      check_rsp("R2 idle outputs low", 1'b0, 0, 0);

      lookup_exp(va_of(20'h00AA1, 5, 0), 2, 0, "R1 empty buffer gives translation miss");
      @(negedge clk);
      check_rsp("R2 response lasts one cycle", 1'b0, 0, 0);

      tlb_write(0, 20'h00AA1, 24'h000501);
      lookup_exp(va_of(20'h00AA1, 5, 3), 1, 0, "R7 translated but absent");
      fill(5, 24'h000501);
      lookup_exp(va_of(20'h00AA1, 5, 0), 0, 0, "R9 first fill takes way 0 / R6");
      lookup_exp(va_of(20'h00AA1, 5, 63), 0, 0, "R3 line offset ignored");
      lookup_exp(va_of(20'h00AA1, 6, 0), 1, 0, "R3 other set index misses");

      tlb_write(1, 20'h0BEEF, 24'h000501);
      lookup_exp(va_of(20'h0BEEF, 5, 17), 0, 0, "R8 alias hits same way");

      fill(5, 24'h000601);
      fill(5, 24'h000602);
      fill(5, 24'h000603);
      tlb_write(2, 20'h00C01, 24'h000601);
      lookup_exp(va_of(20'h00C01, 5, 0), 0, 1, "R9 second fill takes way 1");

      fill(5, 24'h000501);
      lookup_exp(va_of(20'h00AA1, 5, 0), 0, 0, "R11 duplicate fill keeps single copy");
      fill(5, 24'h000604);
      tlb_write(3, 20'h00D01, 24'h000604);
      lookup_exp(va_of(20'h00AA1, 5, 0), 1, 0, "R10 pointer victim way 0 evicted");
      lookup_exp(va_of(20'h00D01, 5, 0), 0, 0, "R10 new line in way 0 / R11 pointer not moved");
      fill(5, 24'h000605);
      lookup_exp(va_of(20'h00C01, 5, 0), 1, 0, "R10 pointer advanced to way 1");

      tlb_write(4, 20'h00E01, 24'h000602);
      tlb_write(5, 20'h00E01, 24'h000603);
      lookup_exp(va_of(20'h00E01, 5, 0), 0, 2, "R4 lowest entry wins");
      tlb_write(4, 20'h00F01, 24'h000602);
      lookup_exp(va_of(20'h00E01, 5, 0), 0, 3, "R4 overwrite replaces entry");

      tlb_write(6, 20'h01234, 24'h000999);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va_of(20'h01234, 9, 0);
      fill_valid = 1'b1; fill_set = 6'd9; fill_ptag = 24'h000999;
      @(negedge clk);
      req_valid = 1'b0; fill_valid = 1'b0;
      check_rsp("R12 same-cycle lookup sees old set", 1'b1, 1, 0);
      m_fill(9, 24'h000999);
      lookup_exp(va_of(20'h01234, 9, 0), 0, 0, "R12 line visible afterwards");

      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_reset();
      check_rsp("R1 outputs low after reset", 1'b0, 0, 0);
      lookup_exp(va_of(20'h00AA1, 5, 0), 2, 0, "R1 translations cleared");
      tlb_write(0, 20'h00AA1, 24'h000501);
      lookup_exp(va_of(20'h00AA1, 5, 0), 1, 0, "R1 cache lines cleared");

      for (int i = 0; i < 4000; i++) begin
         int op = int'($urandom_range(0, 99));
         if (op < 10) begin
            tlb_write(int'($urandom_range(0, 7)), 20'($urandom_range(1, 12)),
                      24'($urandom_range(1, 10)));
         end else if (op < 45) begin
            fill(int'($urandom_range(0, 3)), 24'($urandom_range(1, 10)));
         end else begin
            lookup(va_of(20'($urandom_range(1, 14)), int'($urandom_range(0, 3)),
                         int'($urandom_range(0, 63))), "R6 R7 R10 random lookup");
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule